// File: doc/BRIEF.md
# Hall Commutation Decoder with Low-Side PWM

This block turns the three digitized rotor position sensor bits of a brushless motor into the six switch enables of a three-phase bridge. Each phase has a high-side (source) enable and a low-side (sink) enable. For every valid sensor code exactly one phase sources and one other phase sinks. Reverse rotation is obtained by complementing all three sensor bits before the lookup.

Drive strength is set by chopping only the low-side switch with an externally generated PWM pulse (`pwm_on`, high for the on-time of each period). The high-side switch stays on for the whole commutation step. A peak current comparator flag ends the low-side on-time of the current PWM period early. A stop input forces every switch off. The direction input is sampled only while stopped, so the rotation sense cannot flip while the motor is running.

All outputs are registered. Each output reflects the inputs that were present at the previous rising clock edge.

Top module: `hall_pwm_commutator`

## Requirements
- R1: With the latched direction forward, the sensor code is read as `hall[2]`=IN1, `hall[1]`=IN2, `hall[0]`=IN3. Phase n maps to bit n-1 of `hi_en` and of `lo_en`. The codes map as follows (source/sink): 110→3/2, 100→3/1, 101→2/1, 001→2/3, 011→1/3, 010→1/2.
- R2: With the latched direction reverse (`dir_rev`=1), the lookup of R1 is applied to the bitwise complement of `hall`.
- R3: While `stop`=1 at a clock edge, all six enables are 0 after that edge. `stop`=0 means run.
- R4: The sensor codes 000 and 111 (after any reversal) drive all six enables to 0.
- R5: The high-side enable of a step does not depend on `pwm_on`, `ilim` or the current-limit state.
- R6: The low-side enable of the sinking phase is 1 only after an edge at which `pwm_on`=1.
- R7: An edge with `ilim`=1 and `pwm_on`=1 turns the low side off. It stays off at later edges until an edge with `pwm_on`=0 has been seen.
- R8: `dir_rev` is sampled only at edges where `stop`=1. While running, a change of `dir_rev` has no effect. The value present at the last stopped edge is used after the next start.
- R9: The high-side and low-side enables of the same phase are never 1 together.
- R10: Under reset all enables are 0 and the direction is forward. Outputs follow the inputs with one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hall | input | 3 | Digitized sensor bits, [2]=IN1, [1]=IN2, [0]=IN3 |
| dir_rev | input | 1 | Direction request, 1 = reverse |
| stop | input | 1 | 1 = stop (all off), 0 = run |
| pwm_on | input | 1 | PWM pulse, high during the on-time |
| ilim | input | 1 | Peak current comparator flag |
| hi_en | output | 3 | High-side source enables, bit n-1 = phase n |
| lo_en | output | 3 | Low-side sink enables, bit n-1 = phase n |

## Verification
The assertions take for granted that every input is already synchronous to `clk`. This means the sensor bits, the PWM pulse and the comparator flag have been resynchronized upstream and change only between edges. The checks depend on this because they relate each output to the input values at the preceding edge. The bench changes all inputs on the falling edge and samples outputs on the next falling edge, so every input is stable around each rising edge. The random stimulus includes the invalid codes, direction flips while running and current-limit pulses inside PWM on-times.

// File: rtl/hall_pwm_commutator.sv
module hall_pwm_commutator (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall,
  input  logic       dir_rev,
  input  logic       stop,
  input  logic       pwm_on,
  input  logic       ilim,
  output logic [2:0] hi_en,
  output logic [2:0] lo_en
);

  logic       dir_q;
  logic       cut_q;
  logic [2:0] code;
  logic [2:0] src;
  logic [2:0] snk;
  logic       run;
  logic       chop_ok;

  assign code = dir_q ? ~hall : hall;

  always_comb begin
    src = 3'b000;
    snk = 3'b000;
    case (code)
      3'b110: begin src = 3'b100; snk = 3'b010; end
      3'b100: begin src = 3'b100; snk = 3'b001; end
      3'b101: begin src = 3'b010; snk = 3'b001; end
      3'b001: begin src = 3'b010; snk = 3'b100; end
      3'b011: begin src = 3'b001; snk = 3'b100; end
      3'b010: begin src = 3'b001; snk = 3'b010; end
      default: begin src = 3'b000; snk = 3'b000; end
    endcase
  end

  assign run     = !stop && (src != 3'b000);
  assign chop_ok = pwm_on && !ilim && !cut_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_en <= 3'b000;
      lo_en <= 3'b000;
      dir_q <= 1'b0;
      cut_q <= 1'b0;
    end else begin
      hi_en <= run ? src : 3'b000;
      lo_en <= (run && chop_ok) ? snk : 3'b000;
      if (stop) dir_q <= dir_rev;
      cut_q <= pwm_on && (cut_q || ilim);
    end
  end

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n) (hi_en & lo_en) == 3'b000); // R9
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hi_en) && $onehot0(lo_en)); // R1
  AST_STOP_OFF: assert property (@(posedge clk) disable iff (!rst_n) stop |=> (hi_en == 3'b000 && lo_en == 3'b000)); // R3
  AST_BAD_HALL: assert property (@(posedge clk) disable iff (!rst_n) (hall == 3'b000 || hall == 3'b111) |=> (hi_en == 3'b000 && lo_en == 3'b000)); // R4
  AST_CHOP_LOW: assert property (@(posedge clk) disable iff (!rst_n) !pwm_on |=> lo_en == 3'b000); // R6
  AST_ILIM_CUT: assert property (@(posedge clk) disable iff (!rst_n) ilim |=> lo_en == 3'b000); // R7
  AST_CUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cut_q && pwm_on) |=> lo_en == 3'b000); // R7
  AST_LO_NEEDS_HI: assert property (@(posedge clk) disable iff (!rst_n) (lo_en != 3'b000) |-> (hi_en != 3'b000)); // R5

endmodule

// File: tb/hall_pwm_commutator_test.sv
`timescale 1ns/1ps
module hall_pwm_commutator_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall = 3'b000;
  logic       dir_rev = 1'b0;
  logic       stop = 1'b1;
  logic       pwm_on = 1'b0;
  logic       ilim = 1'b0;
  logic [2:0] hi_en;
  logic [2:0] lo_en;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic m_dir = 1'b0;
  logic m_cut = 1'b0;

  always #4 clk = ~clk;

  hall_pwm_commutator uut (
    .clk(clk), .rst_n(rst_n), .hall(hall), .dir_rev(dir_rev), .stop(stop),
    .pwm_on(pwm_on), .ilim(ilim), .hi_en(hi_en), .lo_en(lo_en)
  );

  // returns {source, sink}, phase n at bit n-1
  function automatic logic [5:0] step_of(input logic [2:0] c);
    logic [2:0] s, k;
    s = 3'b000; k = 3'b000;
    if (c != 3'b000 && c != 3'b111) begin
      if (c[2] && !c[0]) s = 3'b100;
      else if (c[0] && !c[2]) s = (c == 3'b011) ? 3'b001 : 3'b010;
      else s = (c == 3'b101) ? 3'b010 : 3'b001;
      if (c == 3'b010) s = 3'b001;
      if (c == 3'b001) s = 3'b010;
      case (s)
        3'b100: k = c[1] ? 3'b010 : 3'b001;
        3'b010: k = c[2] ? 3'b001 : 3'b100;
        default: k = c[2] ? 3'b010 : (c[0] ? 3'b100 : 3'b010);
      endcase
    end
    return {s, k};
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] h, input logic d, input logic s,
                      input logic p, input logic i, input string tag);
    logic [2:0] c;
    logic [5:0] t;
    logic [2:0] ehi, elo;
    hall = h; dir_rev = d; stop = s; pwm_on = p; ilim = i;
    c = m_dir ? ~h : h;
    t = step_of(c);
    ehi = s ? 3'b000 : t[5:3];
    elo = (s || !p || i || m_cut) ? 3'b000 : t[2:0];
    if (s) m_dir = d;
    m_cut = p && (m_cut || i);
    @(negedge clk);
    if (tag != "") begin
      check({tag, " hi"}, hi_en, ehi);
      check({tag, " lo"}, lo_en, elo);
    end else begin
      check(s ? "R3 hi" : (t == 6'd0 ? "R4 hi" : (m_dir ? "R2 R5 hi" : "R1 R5 hi")), hi_en, ehi);
      check((m_cut || i) ? "R7 lo" : "R6 lo", lo_en, elo);
    end
    check("R9 overlap", hi_en & lo_en, 3'b000);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [2:0] fwd [6];
    fwd = '{3'b110, 3'b100, 3'b101, 3'b001, 3'b011, 3'b010};
    void'($urandom(32'd1921));
    hall = 3'b110; stop = 1'b0; pwm_on = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 reset hi", hi_en, 3'b000);
    check("R10 reset lo", lo_en, 3'b000);
    rst_n = 1'b1;
    // first step: direction reset to forward
    step(3'b110, 1'b0, 1'b0, 1'b1, 1'b0, "R10");
    check("R1 HHL", {hi_en, lo_en}, 6'b100_010);
    foreach (fwd[k]) step(fwd[k], 1'b0, 1'b0, 1'b1, 1'b0, "R1");
    step(3'b000, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
    step(3'b111, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
    // R8: direction change while running is ignored
    step(3'b100, 1'b1, 1'b0, 1'b1, 1'b0, "R8");
    check("R8 held fwd", {hi_en, lo_en}, 6'b100_001);
    step(3'b100, 1'b1, 1'b1, 1'b1, 1'b0, "R3");
    step(3'b011, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    check("R8 reverse latched", {hi_en, lo_en}, 6'b100_001);
    foreach (fwd[k]) step(~fwd[k], 1'b0, 1'b0, 1'b1, 1'b0, "R2");
    step(3'b000, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    step(3'b110, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
    // R5/R6/R7 chopping with current limit
    step(3'b110, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    check("R5 hi during off-time", hi_en, 3'b100);
    step(3'b110, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
    step(3'b110, 1'b0, 1'b0, 1'b1, 1'b1, "R7");
    step(3'b110, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    check("R7 stays cut", lo_en, 3'b000);
    check("R5 hi during cut", hi_en, 3'b100);
    step(3'b110, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    step(3'b110, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    check("R7 next period", lo_en, 3'b010);
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] h;
      h = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(0, 1) * 7) : fwd[$urandom_range(0, 5)];
      step(h, 1'($urandom_range(0, 1)), ($urandom_range(0, 15) == 0),
           ($urandom_range(0, 3) != 0), ($urandom_range(0, 9) == 0), "");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule